// File: doc/BRIEF.md
# Halfword-Swapping DMA Data Path

This block moves data between a 16-bit peripheral and system memory. A transfer request carries a direction, a byte offset, a byte length and a flag that bypasses the byte exchange. The memory address is built by ORing the offset with a base value. Software loads that base value into a register beforehand.

In swap mode, the block clears the lowest bit of both the address and the length. It then exchanges the two bytes inside every halfword that crosses it. This applies in both directions.

Writes to memory in swap mode are cut into bursts of at most `MAX_BURST` bytes. The address moves forward by each burst's size. Bypassed transfers and reads go out as a single burst carrying the exact address and length. Every burst starts with a command beat on its own valid/ready channel. The data beats follow on a write-data or read-data channel. When the last data beat completes, the block raises a single-cycle `done` pulse.

Top module: `hwswap_dma`

## Requirements
- R1: After reset, `req_ready` is 1, `mcmd_valid`, `mwd_valid`, `pout_valid`, `pin_ready`, `mrd_ready` and `done` are 0, and the base register holds 0.
- R2: The burst address is `req_offset | base`, where base is the value last loaded through `base_we`/`base_wdata` before the request is accepted.
- R3: When `req_bypass` is 0 (swap mode), bit 0 of the burst address and bit 0 of the transfer length are forced to 0.
- R4: A swap-mode write (`req_rd`=0) is issued as bursts of `min(MAX_BURST, remaining)` bytes, with MAX_BURST=64 by default. Each burst's address is the previous address plus the previous burst length. A command is held stable until it is accepted.
- R5: A bypassed transfer is issued as one burst with the unmodified ORed address and the full length. It uses ceil(len/2) data beats, and the data passes through unchanged.
- R6: In a swap-mode write, each beat reaches memory with its two bytes exchanged. Byte 0 travels in bits 7:0, so peripheral word {b1,b0} becomes {b0,b1}. `mwd_last` is 1 on the final beat of each burst.
- R7: A read (`req_rd`=1) is issued as one burst with `mcmd_write`=0. In swap mode, memory word {b1,b0} reaches the peripheral as {b0,b1}.
- R8: A transfer whose length is 0 after alignment issues no command and no data beat. `done` is 1 in the cycle after the request is accepted.
- R9: `done` is 1 for exactly one cycle, and that cycle directly follows the clock edge that completes the final data beat.
- R10: `req_ready` is 0 from the accepting edge until `done` has been given. A request held on the inputs during that time has no effect on the commands or data issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| base_we | input | 1 | Load strobe for the base register |
| base_wdata | input | ADDR_W | New base value |
| req_valid | input | 1 | Transfer request present |
| req_ready | output | 1 | Block idle and accepting a request |
| req_rd | input | 1 | 1 = memory to peripheral, 0 = peripheral to memory |
| req_bypass | input | 1 | 1 = no byte exchange and no alignment |
| req_offset | input | ADDR_W | Byte offset ORed with the base |
| req_len | input | LEN_W | Transfer length in bytes |
| pin_valid | input | 1 | Peripheral write data present |
| pin_ready | output | 1 | Peripheral write beat taken |
| pin_data | input | DATA_W | Peripheral write data, byte 0 in bits 7:0 |
| pout_valid | output | 1 | Read data toward the peripheral present |
| pout_ready | input | 1 | Peripheral takes the read beat |
| pout_data | output | DATA_W | Read data toward the peripheral |
| mcmd_valid | output | 1 | Burst command present |
| mcmd_ready | input | 1 | Memory accepts the command |
| mcmd_write | output | 1 | 1 = write burst, 0 = read burst |
| mcmd_addr | output | ADDR_W | Burst start byte address |
| mcmd_len | output | LEN_W | Burst length in bytes |
| mwd_valid | output | 1 | Write data beat present |
| mwd_ready | input | 1 | Memory accepts the write beat |
| mwd_data | output | DATA_W | Write data toward memory |
| mwd_last | output | 1 | Final beat of the current burst |
| mrd_valid | input | 1 | Read data beat from memory present |
| mrd_ready | output | 1 | Read beat taken |
| mrd_data | input | DATA_W | Read data from memory |
| done | output | 1 | Single-cycle transfer completion |

## Verification
Swap-mode writes are swept over every length from 0 to 140 at an odd offset. This separates the alignment of odd lengths, the zero-length shortcut, exact multiples of the burst size, and the lengths one halfword past a burst boundary, where a short final burst must appear. Bypassed writes and reads of odd and even lengths show that the exact address, the exact length and unexchanged data survive when swap is off. A base with bit 0 set shows that alignment is applied after the OR and not before it. The handshakes stall in rotating patterns that differ per channel. A conflicting request is held on the inputs for the whole transfer, which shows that data order, command stability and done timing do not depend on when the far side is ready.

// File: rtl/hwswap_dma_pkg.sv
package hwswap_dma_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_CMD  = 2'd1,
      ST_DATA = 2'd2,
      ST_FIN  = 2'd3
   } xfer_state_t;

endpackage

// File: rtl/hwswap_addr.sv
module hwswap_addr #(
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 16
) (
   input  logic [ADDR_W-1:0] offset,
   input  logic [ADDR_W-1:0] base,
   input  logic [LEN_W-1:0]  len_in,
   input  logic              swap,
   output logic [ADDR_W-1:0] addr_out,
   output logic [LEN_W-1:0]  len_out,
   output logic              len_zero
);
   logic [ADDR_W-1:0] merged;

   always_comb begin
      merged   = offset | base;
      addr_out = {merged[ADDR_W-1:1], merged[0] & ~swap};
      len_out  = {len_in[LEN_W-1:1], len_in[0] & ~swap};
      len_zero = (len_out == '0);
   end
endmodule

// File: rtl/hwswap_lane.sv
module hwswap_lane #(
   parameter int DATA_W = 16
) (
   input  logic              swap,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout
);
   localparam int HALVES = DATA_W / 16;

   for (genvar h = 0; h < HALVES; h++) begin : g_half
      always_comb begin
         if (swap) dout[16*h +: 16] = {din[16*h +: 8], din[16*h+8 +: 8]};
         else      dout[16*h +: 16] = din[16*h +: 16];
      end
   end
endmodule

// File: rtl/hwswap_seq.sv
module hwswap_seq
   import hwswap_dma_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int LEN_W     = 16,
   parameter int DATA_W    = 16,
   parameter int MAX_BURST = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_rd,
   input  logic              req_swap,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [LEN_W-1:0]  start_len,
   input  logic              start_zero,
   output logic              mcmd_valid,
   input  logic              mcmd_ready,
   output logic              mcmd_write,
   output logic [ADDR_W-1:0] mcmd_addr,
   output logic [LEN_W-1:0]  mcmd_len,
   input  logic              beat_fire,
   output logic              beat_last,
   output logic              data_phase,
   output logic              rd_mode,
   output logic              swap_mode,
   output logic              done
);
   localparam int BEAT_BYTES = DATA_W / 8;
   localparam int BEAT_SH    = $clog2(BEAT_BYTES);
   localparam logic [LEN_W-1:0] MAX_LEN  = LEN_W'(MAX_BURST);
   localparam logic [LEN_W:0]   ROUND_UP = (LEN_W+1)'(BEAT_BYTES - 1);

   xfer_state_t       state_q;
   logic [ADDR_W-1:0] addr_q;
   logic [LEN_W-1:0]  rem_q;
   logic [LEN_W-1:0]  beats_q;
   logic              rd_q;
   logic              swap_q;
   logic [LEN_W-1:0]  chunk;
   logic [LEN_W:0]    round_sum;
   logic [LEN_W-1:0]  chunk_beats;
   logic              split;

   always_comb begin
      split       = swap_q && !rd_q && (rem_q > MAX_LEN);
      chunk       = split ? MAX_LEN : rem_q;
      round_sum   = {1'b0, chunk} + ROUND_UP;
      chunk_beats = LEN_W'(round_sum >> BEAT_SH);
   end

   assign req_ready  = (state_q == ST_IDLE);
   assign mcmd_valid = (state_q == ST_CMD);
   assign mcmd_write = !rd_q;
   assign mcmd_addr  = addr_q;
   assign mcmd_len   = chunk;
   assign data_phase = (state_q == ST_DATA);
   assign beat_last  = (beats_q == LEN_W'(1));
   assign rd_mode    = rd_q;
   assign swap_mode  = swap_q;
   assign done       = (state_q == ST_FIN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         addr_q  <= '0;
         rem_q   <= '0;
         beats_q <= '0;
         rd_q    <= 1'b0;
         swap_q  <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  addr_q  <= start_addr;
                  rem_q   <= start_len;
                  rd_q    <= req_rd;
                  swap_q  <= req_swap;
                  state_q <= start_zero ? ST_FIN : ST_CMD;
               end
            end
            ST_CMD: begin
               if (mcmd_ready) begin
                  beats_q <= chunk_beats;
                  addr_q  <= addr_q + ADDR_W'(chunk);
                  rem_q   <= rem_q - chunk;
                  state_q <= ST_DATA;
               end
            end
            ST_DATA: begin
               if (beat_fire) begin
                  beats_q <= beats_q - LEN_W'(1);
                  if (beats_q == LEN_W'(1))
                     state_q <= (rem_q == '0) ? ST_FIN : ST_CMD;
               end
            end
            ST_FIN: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/hwswap_dma.sv
module hwswap_dma
   import hwswap_dma_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int LEN_W     = 16,
   parameter int DATA_W    = 16,
   parameter int MAX_BURST = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              base_we,
   input  logic [ADDR_W-1:0] base_wdata,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_rd,
   input  logic              req_bypass,
   input  logic [ADDR_W-1:0] req_offset,
   input  logic [LEN_W-1:0]  req_len,
   input  logic              pin_valid,
   output logic              pin_ready,
   input  logic [DATA_W-1:0] pin_data,
   output logic              pout_valid,
   input  logic              pout_ready,
   output logic [DATA_W-1:0] pout_data,
   output logic              mcmd_valid,
   input  logic              mcmd_ready,
   output logic              mcmd_write,
   output logic [ADDR_W-1:0] mcmd_addr,
   output logic [LEN_W-1:0]  mcmd_len,
   output logic              mwd_valid,
   input  logic              mwd_ready,
   output logic [DATA_W-1:0] mwd_data,
   output logic              mwd_last,
   input  logic              mrd_valid,
   output logic              mrd_ready,
   input  logic [DATA_W-1:0] mrd_data,
   output logic              done
);
   localparam int BEAT_BYTES = DATA_W / 8;

   if (DATA_W < 16 || (DATA_W % 16) != 0) begin : g_bad_data_w
      $error("hwswap_dma: DATA_W must be a nonzero multiple of 16");
   end
   if ((MAX_BURST & (MAX_BURST - 1)) != 0 || MAX_BURST < BEAT_BYTES) begin : g_bad_burst
      $error("hwswap_dma: MAX_BURST must be a power of two of at least one beat");
   end
   if (MAX_BURST >= (1 << LEN_W)) begin : g_bad_len_w
      $error("hwswap_dma: MAX_BURST does not fit in LEN_W");
   end
   if (ADDR_W < 2) begin : g_bad_addr_w
      $error("hwswap_dma: ADDR_W too small");
   end

   logic [ADDR_W-1:0] base_q;
   logic [ADDR_W-1:0] start_addr;
   logic [LEN_W-1:0]  start_len;
   logic              start_zero;
   logic              data_phase;
   logic              rd_mode;
   logic              swap_q;
   logic              beat_last;
   logic              beat_fire;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       base_q <= '0;
      else if (base_we) base_q <= base_wdata;
   end

   hwswap_addr #(
      .ADDR_W (ADDR_W),
      .LEN_W  (LEN_W)
   ) u_addr (
      .offset   (req_offset),
      .base     (base_q),
      .len_in   (req_len),
      .swap     (!req_bypass),
      .addr_out (start_addr),
      .len_out  (start_len),
      .len_zero (start_zero)
   );

   hwswap_seq #(
      .ADDR_W    (ADDR_W),
      .LEN_W     (LEN_W),
      .DATA_W    (DATA_W),
      .MAX_BURST (MAX_BURST)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_ready  (req_ready),
      .req_rd     (req_rd),
      .req_swap   (!req_bypass),
      .start_addr (start_addr),
      .start_len  (start_len),
      .start_zero (start_zero),
      .mcmd_valid (mcmd_valid),
      .mcmd_ready (mcmd_ready),
      .mcmd_write (mcmd_write),
      .mcmd_addr  (mcmd_addr),
      .mcmd_len   (mcmd_len),
      .beat_fire  (beat_fire),
      .beat_last  (beat_last),
      .data_phase (data_phase),
      .rd_mode    (rd_mode),
      .swap_mode  (swap_q),
      .done       (done)
   );

   always_comb begin
      mwd_valid  = data_phase && !rd_mode && pin_valid;
      pin_ready  = data_phase && !rd_mode && mwd_ready;
      pout_valid = data_phase && rd_mode && mrd_valid;
      mrd_ready  = data_phase && rd_mode && pout_ready;
      mwd_last   = data_phase && !rd_mode && beat_last;
      beat_fire  = rd_mode ? (pout_valid && pout_ready) : (mwd_valid && mwd_ready);
   end

   hwswap_lane #(.DATA_W(DATA_W)) u_wr_lane (
      .swap (swap_q),
      .din  (pin_data),
      .dout (mwd_data)
   );

   hwswap_lane #(.DATA_W(DATA_W)) u_rd_lane (
      .swap (swap_q),
      .din  (mrd_data),
      .dout (pout_data)
   );
endmodule

// File: rtl/hwswap_dma_chk.sv
module hwswap_dma_chk #(
   parameter int ADDR_W    = 32,
   parameter int LEN_W     = 16,
   parameter int MAX_BURST = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              mcmd_valid,
   input logic              mcmd_ready,
   input logic              mcmd_write,
   input logic [ADDR_W-1:0] mcmd_addr,
   input logic [LEN_W-1:0]  mcmd_len,
   input logic              mwd_valid,
   input logic              pout_valid,
   input logic              swap_q,
   input logic              done
);
   AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      mcmd_valid && !mcmd_ready |=> mcmd_valid && $stable(mcmd_addr) && $stable(mcmd_len)); // R4
   AST_CHUNK_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      mcmd_valid && mcmd_write && swap_q |-> mcmd_len <= LEN_W'(MAX_BURST)); // R4
   AST_SWAP_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      mcmd_valid && swap_q |-> !mcmd_addr[0] && !mcmd_len[0]); // R3
   AST_NO_EMPTY_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      mcmd_valid |-> mcmd_len != '0); // R8
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R9
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !mcmd_valid && !mwd_valid && !pout_valid && !done); // R10
endmodule

bind hwswap_dma hwswap_dma_chk #(
   .ADDR_W    (ADDR_W),
   .LEN_W     (LEN_W),
   .MAX_BURST (MAX_BURST)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_ready  (req_ready),
   .mcmd_valid (mcmd_valid),
   .mcmd_ready (mcmd_ready),
   .mcmd_write (mcmd_write),
   .mcmd_addr  (mcmd_addr),
   .mcmd_len   (mcmd_len),
   .mwd_valid  (mwd_valid),
   .pout_valid (pout_valid),
   .swap_q     (swap_q),
   .done       (done)
);

// File: tb/hwswap_dma_tb.sv
module hwswap_dma_tb;
   localparam int ADDR_W = 32;
   localparam int LEN_W  = 16;
   localparam int DATA_W = 16;
   localparam int MAXB   = 64;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic base_we = 1'b0;
   logic [ADDR_W-1:0] base_wdata = '0;
   logic req_valid = 1'b0, req_rd = 1'b0, req_bypass = 1'b0;
   logic [ADDR_W-1:0] req_offset = '0;
   logic [LEN_W-1:0] req_len = '0;
   logic req_ready;
   logic pin_valid = 1'b0, pin_ready;
   logic [DATA_W-1:0] pin_data = '0;
   logic pout_valid, pout_ready = 1'b0;
   logic [DATA_W-1:0] pout_data;
   logic mcmd_valid, mcmd_ready = 1'b0, mcmd_write;
   logic [ADDR_W-1:0] mcmd_addr;
   logic [LEN_W-1:0] mcmd_len;
   logic mwd_valid, mwd_ready = 1'b0, mwd_last;
   logic [DATA_W-1:0] mwd_data;
   logic mrd_valid = 1'b0, mrd_ready;
   logic [DATA_W-1:0] mrd_data = '0;
   logic done;

   int total = 0;
   int bad = 0;
   logic [ADDR_W-1:0] base_m = '0;

   always #4 clk = ~clk;

   hwswap_dma #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W), .MAX_BURST(MAXB)) u_dut (
      .clk(clk), .rst_n(rst_n), .base_we(base_we), .base_wdata(base_wdata),
      .req_valid(req_valid), .req_ready(req_ready), .req_rd(req_rd), .req_bypass(req_bypass),
      .req_offset(req_offset), .req_len(req_len),
      .pin_valid(pin_valid), .pin_ready(pin_ready), .pin_data(pin_data),
      .pout_valid(pout_valid), .pout_ready(pout_ready), .pout_data(pout_data),
      .mcmd_valid(mcmd_valid), .mcmd_ready(mcmd_ready), .mcmd_write(mcmd_write),
      .mcmd_addr(mcmd_addr), .mcmd_len(mcmd_len),
      .mwd_valid(mwd_valid), .mwd_ready(mwd_ready), .mwd_data(mwd_data), .mwd_last(mwd_last),
      .mrd_valid(mrd_valid), .mrd_ready(mrd_ready), .mrd_data(mrd_data), .done(done));

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] pbyte(input int i);
      return 8'((i * 37 + 11) & 255);
   endfunction
   function automatic logic [15:0] pword(input int k);
      return {pbyte(2*k+1), pbyte(2*k)};
   endfunction
   function automatic logic [15:0] mword(input int k);
      return {8'((k * 5 + 3) & 255), 8'((k * 11 + 1) & 255)};
   endfunction
   function automatic logic [15:0] swp(input logic [15:0] w);
      return {w[7:0], w[15:8]};
   endfunction

   task automatic set_base(input logic [ADDR_W-1:0] b);
      @(negedge clk);
      base_we = 1'b1; base_wdata = b;
      @(negedge clk);
      base_we = 1'b0; base_wdata = 32'hFFFF_FFFF;
      base_m = b;
   endtask

   task automatic xfer(input bit rd, input bit byp, input logic [ADDR_W-1:0] off, input int len);
      logic [ADDR_W-1:0] ea [16];
      int el [16];
      int ecnt = 0, tb = 0, ncmd = 0, pk = 0, rk = 0, derr = 0, busy_err = 0;
      int last_fire = 0, done_t = -1, cmd_err = 0;
      logic [ADDR_W-1:0] a;
      int l, rem;
      bit fin = 0, acc = 0;
      a = off | base_m;
      l = len;
      if (!byp) begin a[0] = 1'b0; l = len & ~1; end
      rem = l;
      while (rem > 0) begin
         int c;
         c = (!byp && !rd && rem > MAXB) ? MAXB : rem;
         ea[ecnt] = a; el[ecnt] = c; ecnt++;
         tb += (c + 1) / 2;
         a += ADDR_W'(c); rem -= c;
      end
      for (int t = 0; t < 4000 && !fin; t++) begin
         @(negedge clk);
         if (t == 0) begin
            req_valid = 1'b1; req_rd = rd; req_bypass = byp;
            req_offset = off; req_len = LEN_W'(len);
         end else begin
            req_valid = 1'b1; req_rd = ~rd; req_bypass = ~byp;
            req_offset = 32'h00DE_A001; req_len = 16'd7;
         end
         mcmd_ready = (t % 3) != 1;
         mwd_ready  = (t % 4) != 2;
         pin_valid  = (t % 5) != 3;
         pin_data   = pword(pk);
         mrd_valid  = (t % 5) != 3;
         mrd_data   = mword(rk);
         pout_ready = (t % 4) != 2;
         #1;
         if (t == 0) acc = req_ready;
         else if (req_ready) busy_err++;
         if (mcmd_valid && mcmd_ready) begin
            if (ncmd >= ecnt || mcmd_addr !== ea[ncmd] || int'(mcmd_len) != el[ncmd]
                || mcmd_write !== !rd) cmd_err++;
            ncmd++;
         end
         if (mwd_valid && mwd_ready) begin
            bit lst;
            lst = (pk == tb - 1) || (!byp && ((pk + 1) % (MAXB / 2) == 0));
            if (rd || mwd_data !== (byp ? pword(pk) : swp(pword(pk))) || mwd_last !== lst) derr++;
            pk++; last_fire = t;
         end
         if (pout_valid && pout_ready) begin
            if (!rd || pout_data !== (byp ? mword(rk) : swp(mword(rk)))) derr++;
            rk++; last_fire = t;
         end
         if (done) begin done_t = t; fin = 1; req_valid = 1'b0; end
      end
      if (!fin) begin
         req_valid = 1'b0;
         check(0, "watchdog R9", 0, 1);
      end
      check(acc, "R1 R10 request accepted while idle", acc, 1);
      check(ncmd == ecnt && cmd_err == 0, "R2 R3 R4 R5 R7 R8 burst commands", ncmd, ecnt);
      check((rd ? rk : pk) == tb, "R5 R8 data beat count", rd ? rk : pk, tb);
      check(derr == 0, rd ? "R7 read data order and swap" : "R5 R6 write data and last", derr, 0);
      check(busy_err == 0, "R10 ready low while busy", busy_err, 0);
      check(done_t == last_fire + 1, "R8 R9 done timing", done_t, last_fire + 1);
      @(negedge clk);
      #1;
      check(!done, "R9 done is one cycle", done, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1;
      check(req_ready && !mcmd_valid && !mwd_valid && !pout_valid && !pin_ready
            && !mrd_ready && !done, "R1 reset outputs",
            {req_ready, mcmd_valid, mwd_valid, pout_valid, pin_ready, mrd_ready, done}, 7'b1000000);
      rst_n = 1'b1;
      xfer(0, 0, 32'h0000_0203, 4);
      set_base(32'h0001_0000);
      for (int n = 0; n <= 140; n++) xfer(0, 0, 32'h0000_0203, n);
      for (int n = 0; n <= 9; n++) xfer(0, 1, 32'h0000_0203, n);
      for (int n = 63; n <= 66; n++) xfer(0, 1, 32'h0000_0203, n);
      set_base(32'h0000_0001);
      xfer(0, 0, 32'h0000_0400, 5);
      xfer(0, 0, 32'h0000_0400, 64);
      xfer(0, 0, 32'h0000_0400, 65);
      xfer(0, 1, 32'h0000_0400, 3);
      for (int n = 0; n <= 20; n++) xfer(1, 0, 32'h0000_1001, n);
      xfer(1, 0, 32'h0000_1001, 130);
      for (int n = 1; n <= 5; n++) xfer(1, 1, 32'h0000_1001, n);
      xfer(1, 1, 32'h0000_1001, 129);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #1_500_000;
      bad++; total++;
      $display("FAIL watchdog R9 actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule